// File: doc/BRIEF.md
# DRAM Byte-Lane Parity Generator and Checker

This block adds one parity bit to each byte lane of a 32-bit DRAM data path. On a write it works out the four parity bits from the outgoing data and drives them on the parity lines. On a read it recomputes parity from the returned data and compares it with the parity lines sampled alongside that data. A single global configuration bit selects odd or even parity for both generation and checking.

A mismatch on any lane can be reported on three independent paths:

- **Error pin.** A one-cycle pulse on the external error pin, gated by the parity-enable bit of the addressed bank.
- **Status bit.** A sticky per-bank status bit, gated by the same bank enable. Software clears it by writing ones through a clear strobe and mask.
- **Bus error.** A one-cycle bus-error pulse for reads issued by an internal master. It is gated only by a global enable and ignores the bank enables.

The DRAM timing and any correction of the data are handled elsewhere.

Top module: `dram_lane_parity`

## Requirements
- R1: While `wr_en` is 1, `par_out[i]` is chosen so that the XOR of `wr_data[8i+7:8i]` and `par_out[i]` equals `cfg_odd` (0 = even parity, 1 = odd parity). `par_oe` equals `wr_en`, in the same cycle, with no register on the path.
- R2: While `wr_en` is 0, `par_out` is all zeros.
- R3: A read is checked only in a cycle where `rd_sample` is 1. Bad parity presented while `rd_sample` is 0 raises no pulse and sets no status bit.
- R4: The following conditions must all hold in one sampled read cycle:
  - at least one lane fails the parity rule of R1, checked against `rd_par`;
  - `bank_par_en[rd_bank]` is 1.

  When they do, `perr` is 1 for exactly the one following cycle.
- R5: Under the same condition as R4, `stat[rd_bank]` becomes 1 on the next cycle. It stays 1 until it is cleared.
- R6: When `stat_clr` is 1, each `stat` bit whose `stat_clr_mask` bit is 1 is cleared on the next cycle. If a clear and a new error for the same bank fall in the same cycle, the bit ends up set.
- R7: `berr` is 1 for the one cycle after a sampled read only when all of the following hold:
  - the read failed parity;
  - `rd_internal` is 1;
  - `cfg_berr_en` is 1.

  It does not depend on `bank_par_en`.
- R8: A read whose lanes all satisfy the selected parity rule raises no `perr` and no `berr`, and sets no status bit. This holds in both even and odd mode.
- R9: While `rst_n` is 0, `perr`, `berr` and all `stat` bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_berr_en | input | 1 | Global enable for bus error on parity failure |
| bank_par_en | input | NBANK | Per-bank parity reporting enable |
| wr_en | input | 1 | Write data phase active |
| wr_data | input | DATA_W | Outgoing write data |
| par_out | output | DATA_W/8 | Generated parity lines |
| par_oe | output | 1 | Parity line output enable |
| rd_sample | input | 1 | Read data sample strobe |
| rd_data | input | DATA_W | Returned read data |
| rd_par | input | DATA_W/8 | Sampled parity lines |
| rd_bank | input | clog2(NBANK) | Bank of the current read |
| rd_internal | input | 1 | Read issued by an internal master |
| stat_clr | input | 1 | Status write-one-to-clear strobe |
| stat_clr_mask | input | NBANK | Bits to clear |
| perr | output | 1 | Parity error pin pulse |
| berr | output | 1 | Bus error pulse for internal masters |
| stat | output | NBANK | Sticky per-bank error status |

## Verification
The status register can be asked to clear a bit and to set that same bit in one cycle. This is provoked by issuing a failing read to a bank while `stat_clr` carries a mask that includes that bank. The bit must read 1 afterwards, while other masked bits in the same write drop to 0. The bench also pairs a failing internal read on a bank whose enable is off with the global bus-error enable on. This checks that `berr` pulses while `perr` and the status bit stay low.

// File: rtl/dram_lane_parity.sv
module dram_lane_parity #(
  parameter int DATA_W = 32,
  parameter int NBANK  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_odd,
  input  logic                     cfg_berr_en,
  input  logic [NBANK-1:0]         bank_par_en,
  input  logic                     wr_en,
  input  logic [DATA_W-1:0]        wr_data,
  output logic [DATA_W/8-1:0]      par_out,
  output logic                     par_oe,
  input  logic                     rd_sample,
  input  logic [DATA_W-1:0]        rd_data,
  input  logic [DATA_W/8-1:0]      rd_par,
  input  logic [$clog2(NBANK)-1:0] rd_bank,
  input  logic                     rd_internal,
  input  logic                     stat_clr,
  input  logic [NBANK-1:0]         stat_clr_mask,
  output logic                     perr,
  output logic                     berr,
  output logic [NBANK-1:0]         stat
);
  localparam int NLANE = DATA_W / 8;

  logic [NLANE-1:0] lane_bad;
  logic             bad, bank_hit;
  logic [NBANK-1:0] set_vec, clr_vec;

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    assign par_out[i]  = wr_en & ((^wr_data[8*i +: 8]) ^ cfg_odd);
    assign lane_bad[i] = ((^rd_data[8*i +: 8]) ^ rd_par[i]) != cfg_odd;
  end

  assign par_oe   = wr_en;
  assign bad      = rd_sample & (|lane_bad);
  assign bank_hit = bad & bank_par_en[rd_bank];
  assign set_vec  = bank_hit ? (NBANK'(1) << rd_bank) : '0;
  assign clr_vec  = stat_clr ? stat_clr_mask : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      perr <= 1'b0;
      berr <= 1'b0;
      stat <= '0;
    end else begin
      perr <= bank_hit;
      berr <= bad & rd_internal & cfg_berr_en;
      stat <= (stat & ~clr_vec) | set_vec;
    end
  end
endmodule

// File: rtl/dram_lane_parity_chk.sv
module dram_lane_parity_chk #(
  parameter int DATA_W = 32,
  parameter int NBANK  = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cfg_odd,
  input logic                     cfg_berr_en,
  input logic [NBANK-1:0]         bank_par_en,
  input logic                     wr_en,
  input logic [DATA_W-1:0]        wr_data,
  input logic [DATA_W/8-1:0]      par_out,
  input logic                     par_oe,
  input logic                     rd_sample,
  input logic [$clog2(NBANK)-1:0] rd_bank,
  input logic                     rd_internal,
  input logic                     stat_clr,
  input logic [NBANK-1:0]         stat_clr_mask,
  input logic                     perr,
  input logic                     berr,
  input logic [NBANK-1:0]         stat
);
  for (genvar i = 0; i < DATA_W/8; i++) begin : g_chk
    assert_lane_rule_R1: assert property (@(posedge clk) disable iff (!rst_n)
      par_oe |-> ((^wr_data[8*i +: 8]) ^ par_out[i]) == cfg_odd);
  end

  assert_idle_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> par_out == '0);

  assert_perr_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    perr |-> $past(rd_sample && bank_par_en[rd_bank]));

  assert_stat_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat & ~$past(stat)) != '0) |-> $past(rd_sample));

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !rd_sample) |=> (stat & $past(stat_clr_mask)) == '0);

  assert_berr_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    berr |-> $past(rd_sample && rd_internal && cfg_berr_en));
endmodule

bind dram_lane_parity dram_lane_parity_chk #(.DATA_W(DATA_W), .NBANK(NBANK)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_odd(cfg_odd), .cfg_berr_en(cfg_berr_en),
  .bank_par_en(bank_par_en), .wr_en(wr_en), .wr_data(wr_data),
  .par_out(par_out), .par_oe(par_oe), .rd_sample(rd_sample),
  .rd_bank(rd_bank), .rd_internal(rd_internal), .stat_clr(stat_clr),
  .stat_clr_mask(stat_clr_mask), .perr(perr), .berr(berr), .stat(stat)
);

// File: tb/dram_lane_parity_test.sv
`timescale 1ns/1ps
module dram_lane_parity_test;
  localparam int DATA_W = 32;
  localparam int NBANK  = 8;
  localparam int NLANE  = DATA_W / 8;

  logic clk = 0, rst_n = 0;
  logic cfg_odd = 0, cfg_berr_en = 0;
  logic [NBANK-1:0] bank_par_en = '0;
  logic wr_en = 0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [NLANE-1:0] par_out;
  logic par_oe;
  logic rd_sample = 0;
  logic [DATA_W-1:0] rd_data = '0;
  logic [NLANE-1:0] rd_par = '0;
  logic [2:0] rd_bank = '0;
  logic rd_internal = 0, stat_clr = 0;
  logic [NBANK-1:0] stat_clr_mask = '0;
  logic perr, berr;
  logic [NBANK-1:0] stat;

  int checks = 0, errors = 0;
  logic obs_perr, obs_berr;

  always #5 clk = ~clk;

  dram_lane_parity #(.DATA_W(DATA_W), .NBANK(NBANK)) uut (.*);

  function automatic logic [NLANE-1:0] exp_par(logic [DATA_W-1:0] d, logic odd);
    logic [NLANE-1:0] p;
    for (int i = 0; i < NLANE; i++) p[i] = (^d[8*i +: 8]) ^ odd;
    return p;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_read(logic [2:0] bank, logic intl, logic [DATA_W-1:0] d,
                         logic [NLANE-1:0] p, logic smp, logic clr, logic [NBANK-1:0] mask);
    @(negedge clk);
    rd_bank = bank; rd_internal = intl; rd_data = d; rd_par = p;
    rd_sample = smp; stat_clr = clr; stat_clr_mask = mask;
    @(negedge clk);
    obs_perr = perr; obs_berr = berr;
    rd_sample = 0; stat_clr = 0; stat_clr_mask = '0;
  endtask

  task automatic t_reset();
    chk("R9 perr", perr, 0);
    chk("R9 berr", berr, 0);
    chk("R9 stat", stat, 0);
    rst_n = 1;
  endtask

  task automatic t_write();
    logic [DATA_W-1:0] pats [4] = '{32'h0000_0000, 32'h0102_0380, 32'hFFFF_FFFE, 32'hA5C3_7E11};
    for (int m = 0; m < 2; m++) begin
      cfg_odd = m[0];
      foreach (pats[k]) begin
        @(negedge clk); wr_en = 1; wr_data = pats[k]; #1;
        chk("R1 par_out", par_out, exp_par(pats[k], cfg_odd));
        chk("R1 par_oe", par_oe, 1);
      end
    end
    @(negedge clk); wr_en = 0; wr_data = 32'h1234_5677; #1;
    chk("R2 idle par_out", par_out, 0);
    chk("R2 idle par_oe", par_oe, 0);
    cfg_odd = 0;
  endtask

  task automatic t_good_reads();
    bank_par_en = '1; cfg_berr_en = 1;
    for (int m = 0; m < 2; m++) begin
      cfg_odd = m[0];
      do_read(3, 1, 32'hDEAD_BEEF, exp_par(32'hDEAD_BEEF, cfg_odd), 1, 0, '0);
      chk("R8 good perr", obs_perr, 0);
      chk("R8 good berr", obs_berr, 0);
      chk("R8 good stat", stat, 0);
    end
    cfg_odd = 0;
  endtask

  task automatic t_no_sample();
    do_read(2, 1, 32'h0F0F_0001, exp_par(32'h0F0F_0001, 0) ^ 4'b0001, 0, 0, '0);
    chk("R3 unsampled perr", obs_perr, 0);
    chk("R3 unsampled berr", obs_berr, 0);
    chk("R3 unsampled stat", stat, 0);
  endtask

  task automatic t_err_external();
    bank_par_en = 8'b0010_0100; cfg_odd = 1;
    do_read(5, 0, 32'h7711_2233, exp_par(32'h7711_2233, 1) ^ 4'b0100, 1, 0, '0);
    chk("R4 perr pulse", obs_perr, 1);
    chk("R7 external no berr", obs_berr, 0);
    chk("R5 stat set", stat, 8'b0010_0000);
    @(negedge clk);
    chk("R4 perr one cycle", perr, 0);
    chk("R5 stat sticky", stat, 8'b0010_0000);
    cfg_odd = 0;
  endtask

  task automatic t_err_internal();
    cfg_berr_en = 1;
    do_read(1, 1, 32'h0000_0100, exp_par(32'h0000_0100, 0) ^ 4'b0010, 1, 0, '0);
    chk("R7 berr with bank off", obs_berr, 1);
    chk("R4 bank off no perr", obs_perr, 0);
    chk("R5 bank off no stat", stat, 8'b0010_0000);
    @(negedge clk);
    chk("R7 berr one cycle", berr, 0);
    cfg_berr_en = 0;
    do_read(2, 1, 32'h8000_0000, exp_par(32'h8000_0000, 0) ^ 4'b1000, 1, 0, '0);
    chk("R7 berr disabled", obs_berr, 0);
    chk("R4 perr bank2", obs_perr, 1);
    chk("R5 stat bank2", stat, 8'b0010_0100);
  endtask

  task automatic t_clear();
    do_read(0, 0, '0, '0, 0, 1, 8'b0000_0100);
    chk("R6 clear bank2", stat, 8'b0010_0000);
    do_read(5, 0, 32'h0000_0001, exp_par(32'h0000_0001, 0) ^ 4'b0001, 1, 1, 8'b0010_0000);
    chk("R6 set wins", stat, 8'b0010_0000);
    bank_par_en = '1;
    do_read(6, 0, 32'h0000_0001, exp_par(32'h0000_0001, 0) ^ 4'b0001, 1, 1, 8'b0010_0000);
    chk("R6 clear other plus set", stat, 8'b0100_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_write();
    t_good_reads();
    t_no_sample();
    t_err_external();
    t_err_internal();
    t_clear();
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule